// File: doc/BRIEF.md
# MMU Access Permission Guard with Fault Status Capture

This block sits behind a page-table walker. For each completed walk it takes the final page entry's 3-bit access field, or the walker's own fault report (level and type), together with the kind of access (load, store, instruction fetch) and the privilege of the requester. It decides whether the access may proceed. When it does not, the block records the fault in a status register and the page-aligned virtual address in an address register. It then raises an instruction-side or a data-side trap, unless traps are suppressed.

Requests arrive on a valid/ready stream. `req_ready` is low while reset is asserted and stays high from the first clock after reset, so the block never applies back-pressure. One request is accepted on every clock edge where both signals are high, and the request fields only need to be stable on that edge. The verdict, grant or deny, comes out as a one-cycle `rsp_valid` pulse. `nf_mode` selects a no-fault mode, and `trap_en` is the processor's global trap enable. Software reads the status through `fsr_rdata`. Pulsing `fsr_rd` for one cycle consumes the value shown there and clears the register on that edge.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is {write, fetch, supervisor}, with write as bit 2, fetch as bit 1 and supervisor as bit 0. A fault stores it in status bits [7:5].
- R2: With no walk fault, the verdict depends on the access field A (0..7). A user access with A of 6 or 7 is a privilege violation, type 3, code 12. Otherwise the following must be permitted, and a missing permission is a protection error, type 2, code 8. A load needs read, which every A except 4 gives. A fetch needs execute, which A of 2, 3 or 4 gives, and also A of 6 or 7 for a supervisor. A store needs write, which A of 1 or 3 gives, and also A of 5 or 7 for a supervisor. A store that is also a fetch needs both write and execute.
- R3: A walk fault always denies the access and skips the permission check. The walk level goes to status bits [9:8] and the walk fault type to bits [4:2]. A permission fault stores level 0.
- R4: When `nf_mode` is set, a permission fault on a user access is waived. The access is granted, and the status and address registers are left unchanged.
- R5: On a fault the status becomes {level, index, type, 1, ow}. Bit 1 marks the address as valid. Bit 0 (ow) is 1 exactly when the status was non-zero before the fault, and the previous contents are otherwise discarded.
- R6: On a fault, `far_rdata` takes the request's virtual address with its low PAGE_BITS bits cleared. A granted access leaves it unchanged.
- R7: A fault raises `itrap` for a fetch and `dtrap` for any other access, one cycle after acceptance. Neither trap is raised when `nf_mode` is set or `trap_en` is low.
- R8: `fsr_rdata` always shows the status register, and a cycle with `fsr_rd` high clears it at the next edge. If a fault is accepted on that same edge, the new status is built as if the old value were zero, so ow is 0.
- R9: `rsp_valid` pulses one cycle after each accepted request. `rsp_grant` is high in that cycle exactly when no fault was recorded, including waived faults.
- R10: After reset, the status, the fault address and all trap and response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk result present |
| req_ready | output | 1 | High from the first cycle after reset |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_write | input | 1 | Access writes |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Supervisor privilege |
| req_acc | input | 3 | Access field of the final page entry |
| req_walk_fault | input | 1 | Walk ended in a fault |
| req_walk_lvl | input | 2 | Level where the walk ended |
| req_walk_ft | input | 3 | Walk fault type |
| nf_mode | input | 1 | No-fault mode |
| trap_en | input | 1 | Trap enable |
| fsr_rd | input | 1 | Consume and clear fault status |
| fsr_rdata | output | 10 | Fault status register |
| far_rdata | output | VA_W | Fault address register |
| rsp_valid | output | 1 | Verdict pulse |
| rsp_grant | output | 1 | Access allowed |
| itrap | output | 1 | Instruction access trap |
| dtrap | output | 1 | Data access trap |

## Verification
The hardest corner to reach is a fault accepted on the same edge as a status read, while the status already holds an earlier fault. Only this combination separates the read-clear priority from the overwrite marking. The bench forces it directly with two faults in a row, where the second one carries `fsr_rd`. It also mixes random read pulses into a long random run, so that faults often land on a non-empty status. Waived user faults in no-fault mode are also directed, to confirm that the status and the address stay untouched.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;
  localparam int ACC_W = 3;
  localparam int IDX_W = 3;
  localparam int LVL_W = 2;
  localparam int FT_W  = 3;
  localparam int FSR_W = LVL_W + IDX_W + FT_W + 2;

  localparam logic [FT_W-1:0] FT_NONE = 3'd0;
  localparam logic [FT_W-1:0] FT_PROT = 3'd2;
  localparam logic [FT_W-1:0] FT_PRIV = 3'd3;
endpackage

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_guard_pkg::*;
(
  input  logic             is_write,
  input  logic             is_fetch,
  input  logic             is_super,
  input  logic [ACC_W-1:0] acc,
  output logic [FT_W-1:0]  verdict
);
  logic may_read, may_write, may_exec, need_ok, user_locked;

  always_comb begin
    may_read  = (acc != 3'd4);
    may_write = (acc == 3'd1) || (acc == 3'd3) ||
                (is_super && ((acc == 3'd5) || (acc == 3'd7)));
    may_exec  = (acc == 3'd2) || (acc == 3'd3) || (acc == 3'd4) ||
                (is_super && ((acc == 3'd6) || (acc == 3'd7)));
    user_locked = !is_super && (acc[2:1] == 2'b11);
    unique case ({is_write, is_fetch})
      2'b00:   need_ok = may_read;
      2'b01:   need_ok = may_exec;
      2'b10:   need_ok = may_write;
      default: need_ok = may_write && may_exec;
    endcase
    if (user_locked)  verdict = FT_PRIV;
    else if (!need_ok) verdict = FT_PROT;
    else              verdict = FT_NONE;
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_guard_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int PAGE_W   = VA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [FT_W-1:0]   ft,
  input  logic [PAGE_W-1:0] page,
  input  logic              rd,
  output logic [FSR_W-1:0]  fsr_q,
  output logic [VA_W-1:0]   far_q
);
  logic [FSR_W-1:0] base;

  assign base = rd ? '0 : fsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (commit) begin
        fsr_q <= {lvl, idx, ft, 1'b1, |base};
        far_q <= {page, {PAGE_BITS{1'b0}}};
      end else begin
        fsr_q <= base;
      end
    end
  end

  // R8: a read without a concurrent fault leaves the status empty
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !commit) |=> (fsr_q == '0));
  // R5: a fault on top of a non-empty, unread status marks overwrite
  a_r5_overwrite_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rd && (fsr_q != '0)) |=> fsr_q[0]);
  // R8: concurrent read and fault yields no overwrite mark
  a_r8_read_wins_ow: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rd) |=> (!fsr_q[0] && fsr_q[1]));
endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import mmu_guard_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             req_super,
  input  logic [2:0]       req_acc,
  input  logic             req_walk_fault,
  input  logic [1:0]       req_walk_lvl,
  input  logic [2:0]       req_walk_ft,
  input  logic             nf_mode,
  input  logic             trap_en,
  input  logic             fsr_rd,
  output logic [9:0]       fsr_rdata,
  output logic [VA_W-1:0]  far_rdata,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic             itrap,
  output logic             dtrap
);
  logic             ready_q, fire, waive, fault, trap_ok;
  logic [FT_W-1:0]  perm_ft, ft_sel;
  logic [LVL_W-1:0] lvl_sel;
  logic [IDX_W-1:0] idx;

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;
  assign idx       = {req_write, req_fetch, req_super};

  mmu_perm_check u_perm (
    .is_write (req_write),
    .is_fetch (req_fetch),
    .is_super (req_super),
    .acc      (req_acc),
    .verdict  (perm_ft)
  );

  always_comb begin
    waive   = !req_walk_fault && (perm_ft != FT_NONE) && nf_mode && !req_super;
    fault   = req_walk_fault || ((perm_ft != FT_NONE) && !waive);
    ft_sel  = req_walk_fault ? req_walk_ft : perm_ft;
    lvl_sel = req_walk_fault ? req_walk_lvl : '0;
    trap_ok = fire && fault && !nf_mode && trap_en;
  end

  mmu_fault_regs #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (fire && fault),
    .idx    (idx),
    .lvl    (lvl_sel),
    .ft     (ft_sel),
    .page   (req_vaddr[VA_W-1:PAGE_BITS]),
    .rd     (fsr_rd),
    .fsr_q  (fsr_rdata),
    .far_q  (far_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      itrap     <= 1'b0;
      dtrap     <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= fire;
      rsp_grant <= fire && !fault;
      itrap     <= trap_ok && req_fetch;
      dtrap     <= trap_ok && !req_fetch;
    end
  end

  // R7: at most one trap kind at a time
  a_r7_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({itrap, dtrap}));
  // R7: no-fault mode never traps
  a_r7_nf_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && nf_mode) |=> (!itrap && !dtrap));
  // R9: a denied verdict always has a valid status entry behind it
  a_r9_deny_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> fsr_rdata[1]);
  // R9: traps only accompany a denied response
  a_r9_trap_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (itrap || dtrap) |-> (rsp_valid && !rsp_grant));
endmodule

// File: tb/sim_mmu_access_guard.sv
module sim_mmu_access_guard;
  localparam int CLK_NS = 10;
  localparam int VA_W = 32;
  localparam int PB = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_fetch = 0, req_super = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [2:0] req_acc = '0, req_walk_ft = '0;
  logic req_walk_fault = 0, nf_mode = 0, trap_en = 0, fsr_rd = 0;
  logic [1:0] req_walk_lvl = '0;
  logic req_ready, rsp_valid, rsp_grant, itrap, dtrap;
  logic [9:0] fsr_rdata;
  logic [VA_W-1:0] far_rdata;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [9:0] fsr_m = '0;
  logic [VA_W-1:0] far_m = '0;

  always #(CLK_NS/2) clk = ~clk;

  mmu_access_guard #(.VA_W(VA_W), .PAGE_BITS(PB)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 reference rows indexed by {write, fetch, super}
  function automatic int ref_code(input logic [2:0] idx, input logic [2:0] a);
    int r[8];
    case (idx)
      3'd0: r = '{0, 0, 0, 0, 8, 0, 12, 12};
      3'd1: r = '{0, 0, 0, 0, 8, 0, 0, 0};
      3'd2: r = '{8, 8, 0, 0, 0, 8, 12, 12};
      3'd3: r = '{8, 8, 0, 0, 0, 8, 0, 0};
      3'd4: r = '{8, 0, 8, 0, 8, 8, 12, 12};
      3'd5: r = '{8, 0, 8, 0, 8, 0, 8, 0};
      3'd6: r = '{8, 8, 8, 0, 8, 8, 12, 12};
      default: r = '{8, 8, 8, 0, 8, 8, 8, 0};
    endcase
    return r[a];
  endfunction

  task automatic step(input logic v, w, f, s, input logic [2:0] a,
                      input logic wf, input logic [1:0] lv, input logic [2:0] ft,
                      input logic [31:0] va, input logic nf, te, rd, input string tag);
    logic [2:0] idx;
    int code;
    logic fault, exp_grant, exp_i, exp_d;
    logic [9:0] base;
    @(negedge clk);
    req_valid = v; req_write = w; req_fetch = f; req_super = s; req_acc = a;
    req_walk_fault = wf; req_walk_lvl = lv; req_walk_ft = ft; req_vaddr = va;
    nf_mode = nf; trap_en = te; fsr_rd = rd;
    if (rd) chk(fsr_rdata == fsr_m, {tag, " R8 read value"}, 32'(fsr_rdata), 32'(fsr_m));
    idx = {w, f, s};
    if (wf) code = (int'(lv) << 8) | (int'(ft) << 2);
    else begin
      code = ref_code(idx, a);
      if (code != 0 && nf && !s) code = 0; // R4 waiver
    end
    fault = v && (wf || code != 0);
    base = rd ? '0 : fsr_m;
    if (fault) begin
      fsr_m = 10'(code) | (10'(idx) << 5) | 10'd2 | ((base != 0) ? 10'd1 : 10'd0);
      far_m = va & ~32'((1 << PB) - 1);
    end else fsr_m = base;
    exp_grant = v && !fault;
    exp_i = fault && !nf && te && f;
    exp_d = fault && !nf && te && !f;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == v, {tag, " R9 rsp_valid"}, 32'(rsp_valid), 32'(v));
    chk(rsp_grant == exp_grant, {tag, " R9/R2 grant"}, 32'(rsp_grant), 32'(exp_grant));
    chk(itrap == exp_i, {tag, " R7 itrap"}, 32'(itrap), 32'(exp_i));
    chk(dtrap == exp_d, {tag, " R7 dtrap"}, 32'(dtrap), 32'(exp_d));
    chk(fsr_rdata == fsr_m, {tag, " R5/R1/R3 status"}, 32'(fsr_rdata), 32'(fsr_m));
    chk(far_rdata == far_m, {tag, " R6 address"}, far_rdata, far_m);
    req_valid = 0; fsr_rd = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 0, "R9 ready low in reset", 32'(req_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk(fsr_rdata == 0, "R10 status reset", 32'(fsr_rdata), 0);
    chk(far_rdata == 0, "R10 address reset", far_rdata, 0);
    chk({rsp_valid, rsp_grant, itrap, dtrap} == 0, "R10 outputs reset",
        32'({rsp_valid, rsp_grant, itrap, dtrap}), 0);
    chk(req_ready == 1, "R9 ready high", 32'(req_ready), 1);

    // directed corners
    step(1,0,0,1,3'd3,0,0,0,32'h1234_5678,0,1,0,"R2 super load grant");
    step(1,1,0,0,3'd6,0,0,0,32'hAAAA_BFFF,0,1,0,"R2 user store priv");
    step(1,0,0,1,3'd4,0,0,0,32'h0000_3123,0,1,0,"R5 overwrite super load prot");
    step(1,0,1,0,3'd1,0,0,0,32'h0040_0001,0,1,1,"R8 fetch fault with read");
    step(1,0,0,0,3'd0,0,0,0,32'h0,0,1,1,"R8 clear by read");
    step(1,1,0,0,3'd2,0,0,0,32'hFFFF_F000,1,1,0,"R4 nf user waived");
    step(1,1,0,1,3'd2,0,0,0,32'h7777_7777,1,1,0,"R7 nf super no trap");
    step(1,0,1,1,3'd0,1,2'd3,3'd1,32'h5555_5555,0,0,0,"R3 walk fault no trap_en");
    step(1,1,1,0,3'd3,1,2'd2,3'd4,32'h0ABC_DEF0,0,1,0,"R3 walk fault over grant acc");
    step(1,1,1,1,3'd6,0,0,0,32'h9000_0000,0,1,1,"R1 store+fetch super");
    step(1,1,0,1,3'd5,0,0,0,32'h8000_1000,0,1,0,"R6 grant keeps address");
    step(0,0,0,0,3'd0,0,0,0,32'h0,0,1,1,"R8 idle read");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv = $urandom;
      logic [31:0] va = $urandom;
      step(rv[0] | rv[1], rv[2], rv[3], rv[4], rv[7:5], (rv[11:8] == 0),
           rv[13:12], rv[16:14], va, (rv[19:17] == 0), rv[20] | rv[21],
           (rv[24:22] == 0), "random R2 R7");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule